// File: doc/BRIEF.md
# Sign-Compression Line Packer

This block lets two cache lines share one physical data slot. A line is eight 32-bit words. A word is sign-compressible when its upper 17 bits are all equal, which means the word is a sign-extended 16-bit value. The compressor keeps only the low 16 bits of every word, so the packed form is a 128-bit half-line.

A line may contain one word that cannot be compressed. That word's upper 16 bits go into a small side field held in spare storage next to the data array. A line with two or more such words is marked as not fitting and has to take a full slot by itself.

The block compresses two candidate lines side by side. It reports whether each line fits and whether the two can be paired. It also assembles the shared slot image. A separate expander rebuilds a full 256-bit line from a packed half-line and its side field. The compressor and the expander each have a latency of one clock cycle.

Top module: `scl_packer`

## Requirements
- R1: A word is compressible exactly when its bits 31 down to 15 are all equal. The fit flag of a line is set when at most one of its eight words is incompressible.
- R2: The packed half-line of a line holds bits 15:0 of word i at bits [16*i+15 : 16*i].
- R3: The side field is 20 bits wide. Bit 19 is the valid bit, bits 18:16 hold the word position and bits 15:0 hold bits 31:16 of the incompressible word. The field is valid only when the line has exactly one incompressible word. In every other case the field is all zero.
- R4: A line with two or more incompressible words has its fit flag cleared.
- R5: The pair-fit output is high only when the fit flags of both lines are high. Bits 127:0 of the slot image hold line A's packed half and bits 255:128 hold line B's packed half.
- R6: Compressor results and the compress-valid output appear one clock after the inputs are presented. When the compress-valid input is low, the result registers keep their previous values.
- R7: One clock after a decompress request, each output word i is built as follows. Its low 16 bits are packed bits [16*i+15 : 16*i]. Its upper 16 bits come from the side field when that field is valid and names position i. Otherwise they are copies of packed bit 16*i+15.
- R8: When a line with its fit flag set is compressed and then expanded, the result equals the original 256-bit line.
- R9: While reset is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid_i | input | 1 | Compress request for both candidate lines |
| line_a_i | input | 256 | First candidate line |
| line_b_i | input | 256 | Second candidate line |
| dec_valid_i | input | 1 | Decompress request |
| dec_half_i | input | 128 | Packed half-line to expand |
| dec_side_i | input | 20 | Side field that belongs to the half-line |
| cmp_valid_o | output | 1 | Compress results valid |
| fit_a_o | output | 1 | Line A fits in a half slot |
| fit_b_o | output | 1 | Line B fits in a half slot |
| pair_fit_o | output | 1 | Both lines can share one slot |
| slot_o | output | 256 | Slot image: line B half in the upper bits, line A half in the lower bits |
| side_a_o | output | 20 | Side field for line A |
| side_b_o | output | 20 | Side field for line B |
| dec_valid_o | output | 1 | Expanded line valid |
| dec_line_o | output | 256 | Expanded 256-bit line |

## Verification
The bench targets the sign boundary. 0x00007FFF and 0xFFFF8000 must pass as compressible, and 0x00008000 and 0xFFFF7FFF must not; a probe that tested one bit too few or too many would misjudge these. It places a single outlier at position 0, at position 7 and in the middle, and it adds cases with two or more outliers. A wrong position encoding, a wrong upper-half mux or a fit rule that allowed two outliers would then show up as a corrupted round trip or a wrong pair-fit.

Random lines go through the compressor and straight back through the expander, with the DUT's own packed output fed to the expander, so any lost bit is caught. Cycles with the compress-valid input low confirm that the result registers hold. Random side fields whose valid bit is clear confirm that the expander ignores the position and upper bits in that case.

// File: rtl/scl_pkg.sv
package scl_pkg;
  parameter int WORD_W     = 32;
  parameter int HALF_W     = 16;
  parameter int LINE_WORDS = 8;

  localparam int POS_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int PACK_W = HALF_W * LINE_WORDS;
  localparam int HEAD_W = WORD_W - HALF_W;
  localparam int SIGN_W = HEAD_W + 1;

  typedef struct packed {
    logic              vld;
    logic [POS_W-1:0]  pos;
    logic [HEAD_W-1:0] upper;
  } side_t;

  localparam int SIDE_W = $bits(side_t);
endpackage

// File: rtl/scl_outlier_finder.sv
module scl_outlier_finder
  import scl_pkg::*;
(
  input  logic [LINE_WORDS*SIGN_W-1:0] heads_i,
  output logic [1:0]                   bad_cnt_o,
  output logic [POS_W-1:0]             first_pos_o
);
  // bad_cnt_o: 0 = none, 1 = exactly one, 2 = two or more
  logic [LINE_WORDS-1:0] bad;

  genvar g;
  generate
    for (g = 0; g < LINE_WORDS; g++) begin : g_probe
      logic [SIGN_W-1:0] head;
      assign head   = heads_i[g*SIGN_W +: SIGN_W];
      assign bad[g] = !((head == '0) || (head == '1));
    end
  endgenerate

  always_comb begin
    bad_cnt_o   = 2'd0;
    first_pos_o = '0;
    for (int i = LINE_WORDS - 1; i >= 0; i--) begin
      if (bad[i]) first_pos_o = POS_W'(i);
    end
    for (int i = 0; i < LINE_WORDS; i++) begin
      if (bad[i] && bad_cnt_o != 2'd2) bad_cnt_o = bad_cnt_o + 2'd1;
    end
  end
endmodule

// File: rtl/scl_compressor.sv
module scl_compressor
  import scl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              valid_o,
  output logic              fit_o,
  output logic [PACK_W-1:0] half_o,
  output side_t             side_o
);
  logic [LINE_WORDS*SIGN_W-1:0] heads;
  logic [PACK_W-1:0]            half_n;
  logic [HEAD_W-1:0]            uppers [LINE_WORDS];
  logic [1:0]                   bad_cnt;
  logic [POS_W-1:0]             first_pos;
  side_t                        side_n;

  genvar g;
  generate
    for (g = 0; g < LINE_WORDS; g++) begin : g_slice
      assign heads[g*SIGN_W +: SIGN_W]  = line_i[g*WORD_W + HALF_W - 1 +: SIGN_W];
      assign half_n[g*HALF_W +: HALF_W] = line_i[g*WORD_W +: HALF_W];
      assign uppers[g]                  = line_i[g*WORD_W + HALF_W +: HEAD_W];
    end
  endgenerate

  scl_outlier_finder u_finder (
    .heads_i    (heads),
    .bad_cnt_o  (bad_cnt),
    .first_pos_o(first_pos)
  );

  always_comb begin
    side_n = '0;
    if (bad_cnt == 2'd1) begin
      side_n.vld   = 1'b1;
      side_n.pos   = first_pos;
      side_n.upper = uppers[first_pos];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      fit_o   <= 1'b0;
      half_o  <= '0;
      side_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        fit_o  <= (bad_cnt != 2'd2);
        half_o <= half_n;
        side_o <= side_n;
      end
    end
  end

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  a_r3_side_needs_fit: assert property (@(posedge clk) disable iff (rst)
    side_o.vld |-> fit_o);
  a_r2_low_half_kept: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (half_o[HALF_W-1:0] == $past(line_i[HALF_W-1:0])));
  a_r3_upper_from_line: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !rst) |=> (!side_o.vld || side_o.upper != {HEAD_W{half_o[side_o.pos*HALF_W + HALF_W - 1]}}));
endmodule

// File: rtl/scl_expander.sv
module scl_expander
  import scl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [PACK_W-1:0] half_i,
  input  side_t             side_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o
);
  logic [LINE_W-1:0] line_n;

  genvar g;
  generate
    for (g = 0; g < LINE_WORDS; g++) begin : g_word
      logic              hit;
      logic [HALF_W-1:0] low;
      assign low = half_i[g*HALF_W +: HALF_W];
      assign hit = side_i.vld && (side_i.pos == POS_W'(g));
      assign line_n[g*WORD_W +: WORD_W] =
        {(hit ? side_i.upper : {HEAD_W{low[HALF_W-1]}}), low};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      line_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) line_o <= line_n;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  a_r7_low_word0: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (line_o[HALF_W-1:0] == $past(half_i[HALF_W-1:0])));
endmodule

// File: rtl/scl_packer.sv
module scl_packer
  import scl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid_i,
  input  logic [LINE_W-1:0] line_a_i,
  input  logic [LINE_W-1:0] line_b_i,
  input  logic              dec_valid_i,
  input  logic [PACK_W-1:0] dec_half_i,
  input  logic [SIDE_W-1:0] dec_side_i,
  output logic              cmp_valid_o,
  output logic              fit_a_o,
  output logic              fit_b_o,
  output logic              pair_fit_o,
  output logic [LINE_W-1:0] slot_o,
  output logic [SIDE_W-1:0] side_a_o,
  output logic [SIDE_W-1:0] side_b_o,
  output logic              dec_valid_o,
  output logic [LINE_W-1:0] dec_line_o
);
  localparam int LANES = 2;

  logic [LINE_W-1:0] lines [LANES];
  logic              vld   [LANES];
  logic              fit   [LANES];
  logic [PACK_W-1:0] halves[LANES];
  side_t             sides [LANES];

  assign lines[0] = line_a_i;
  assign lines[1] = line_b_i;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      scl_compressor u_cmp (
        .clk    (clk),
        .rst    (rst),
        .valid_i(cmp_valid_i),
        .line_i (lines[l]),
        .valid_o(vld[l]),
        .fit_o  (fit[l]),
        .half_o (halves[l]),
        .side_o (sides[l])
      );
    end
  endgenerate

  assign cmp_valid_o = vld[0];
  assign fit_a_o     = fit[0];
  assign fit_b_o     = fit[1];
  assign pair_fit_o  = fit[0] & fit[1];
  assign slot_o      = {halves[1], halves[0]};
  assign side_a_o    = sides[0];
  assign side_b_o    = sides[1];

  scl_expander u_exp (
    .clk    (clk),
    .rst    (rst),
    .valid_i(dec_valid_i),
    .half_i (dec_half_i),
    .side_i (side_t'(dec_side_i)),
    .valid_o(dec_valid_o),
    .line_o (dec_line_o)
  );

  a_r6_lanes_agree: assert property (@(posedge clk) disable iff (rst)
    vld[0] == vld[1]);
  a_r5_pair_only_on_update: assert property (@(posedge clk) disable iff (rst)
    $rose(pair_fit_o) |-> $past(cmp_valid_i));
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!cmp_valid_o && !dec_valid_o && !pair_fit_o));
endmodule

// File: tb/scl_packer_test.sv
module scl_packer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         cmp_valid_i = 1'b0, dec_valid_i = 1'b0;
  logic [255:0] line_a_i = '0, line_b_i = '0;
  logic [127:0] dec_half_i = '0;
  logic [19:0]  dec_side_i = '0;
  logic         cmp_valid_o, fit_a_o, fit_b_o, pair_fit_o, dec_valid_o;
  logic [255:0] slot_o, dec_line_o;
  logic [19:0]  side_a_o, side_b_o;

  scl_packer uut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // expected state
  logic         e_cv = 0, e_fa = 0, e_fb = 0, e_dv = 0;
  logic [255:0] e_slot = '0, e_dl = '0;
  logic [19:0]  e_sa = '0, e_sb = '0;
  logic         rt_pend = 0;
  logic [255:0] rt_line = '0;

  function automatic bit m_ok(logic [31:0] w);
    return (w[31:15] == 17'h0) || (w[31:15] == 17'h1FFFF);
  endfunction

  function automatic int m_bad(logic [255:0] ln);
    int n = 0;
    for (int i = 0; i < 8; i++) if (!m_ok(ln[i*32 +: 32])) n++;
    return n;
  endfunction

  function automatic logic [127:0] m_pack(logic [255:0] ln);
    logic [127:0] p;
    for (int i = 0; i < 8; i++) p[i*16 +: 16] = ln[i*32 +: 16];
    return p;
  endfunction

  function automatic logic [19:0] m_side(logic [255:0] ln);
    if (m_bad(ln) != 1) return 20'h0;
    for (int i = 0; i < 8; i++)
      if (!m_ok(ln[i*32 +: 32])) return {1'b1, 3'(i), ln[i*32+16 +: 16]};
    return 20'h0;
  endfunction

  function automatic logic [255:0] m_expand(logic [127:0] h, logic [19:0] s);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i*32 +: 32] = {{16{h[i*16+15]}}, h[i*16 +: 16]};
      if (s[19] && s[18:16] == 3'(i)) r[i*32+16 +: 16] = s[15:0];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6 cmp_valid", 256'(cmp_valid_o), 256'(e_cv));
    chk("R1 fit_a", 256'(fit_a_o), 256'(e_fa));
    chk("R4 fit_b", 256'(fit_b_o), 256'(e_fb));
    chk("R5 pair_fit", 256'(pair_fit_o), 256'(e_fa & e_fb));
    chk("R2 R5 slot", slot_o, e_slot);
    chk("R3 side_a", 256'(side_a_o), 256'(e_sa));
    chk("R3 side_b", 256'(side_b_o), 256'(e_sb));
    chk("R7 dec_valid", 256'(dec_valid_o), 256'(e_dv));
    chk("R7 dec_line", dec_line_o, e_dl);
    if (rt_pend) chk("R8 round trip", dec_line_o, rt_line);
  endtask

  // one clock: check previous results, then drive new inputs
  task automatic step(logic cv, logic [255:0] la, logic [255:0] lb, bit rnd_dec);
    @(negedge clk);
    compare_all();
    rt_pend = 1'b0;
    // feed the expander from the DUT's own line A result
    dec_valid_i = 1'b1;
    if (rnd_dec) begin
      dec_half_i = {$urandom, $urandom, $urandom, $urandom};
      dec_side_i = 20'($urandom);
    end else begin
      dec_half_i = slot_o[127:0];
      dec_side_i = side_a_o;
      if (e_cv && e_fa) begin rt_pend = 1'b1; rt_line = line_a_i; end
    end
    e_dv = 1'b1;
    e_dl = m_expand(dec_half_i, dec_side_i);
    cmp_valid_i = cv;
    line_a_i = la;
    line_b_i = lb;
    e_cv = cv;
    if (cv) begin
      e_fa = (m_bad(la) <= 1);
      e_fb = (m_bad(lb) <= 1);
      e_slot = {m_pack(lb), m_pack(la)};
      e_sa = m_side(la);
      e_sb = m_side(lb);
    end
  endtask

  function automatic logic [31:0] small_word();
    logic [15:0] v = 16'($urandom);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] big_word();
    logic [31:0] w = $urandom;
    if (m_ok(w)) w[20] = ~w[20];
    return w;
  endfunction

  function automatic logic [255:0] gen_line(int nbad);
    logic [255:0] ln;
    for (int i = 0; i < 8; i++) ln[i*32 +: 32] = small_word();
    for (int k = 0; k < nbad; k++) ln[($urandom % 8)*32 +: 32] = big_word();
    return ln;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] z, la, lb;
    z = '0;
    // reset with busy inputs: outputs must be zero (R9)
    cmp_valid_i = 1'b1; dec_valid_i = 1'b1;
    line_a_i = {8{32'h12345678}}; dec_half_i = '1; dec_side_i = 20'hFFFFF;
    repeat (3) begin
      @(negedge clk);
      chk("R9 reset slot", slot_o, z);
      chk("R9 reset dec", dec_line_o, z);
      chk("R9 reset flags", 256'({cmp_valid_o, fit_a_o, fit_b_o, pair_fit_o, dec_valid_o}), z);
      chk("R9 reset sides", 256'({side_a_o, side_b_o}), z);
    end
    cmp_valid_i = 1'b0; dec_valid_i = 1'b0; line_a_i = '0;
    dec_half_i = '0; dec_side_i = '0;
    @(negedge clk);
    rst = 1'b0;

    // R1 sign boundary: 0x7FFF and 0xFFFF8000 fit, 0x8000 and 0xFFFF7FFF do not
    step(1'b1, z, z, 1'b0);
    la = z; la[0 +: 32] = 32'h00007FFF; la[32 +: 32] = 32'hFFFF8000;
    lb = z; lb[0 +: 32] = 32'h00008000; lb[224 +: 32] = 32'hFFFF7FFF;
    step(1'b1, la, lb, 1'b0);
    // R3 single outlier at position 0 and at position 7
    la = z; la[0 +: 32] = 32'hDEADBEEF;
    lb = {8{32'hFFFFFFFF}}; lb[224 +: 32] = 32'h7FFF0001;
    step(1'b1, la, lb, 1'b0);
    // R4 two and three outliers
    la = z; la[64 +: 32] = 32'h00010000; la[96 +: 32] = 32'h80000000;
    lb = gen_line(0); lb[0 +: 32] = 32'h40000000; lb[128 +: 32] = 32'h00020000; lb[160 +: 32] = 32'hF0000000;
    step(1'b1, la, lb, 1'b0);
    // R6 hold when valid low
    step(1'b0, gen_line(2), gen_line(1), 1'b0);
    step(1'b0, gen_line(0), gen_line(3), 1'b0);
    step(1'b1, gen_line(1), gen_line(0), 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic cv;
      cv = ($urandom % 8) != 0;
      step(cv, gen_line($urandom % 3), gen_line($urandom % 3), ($urandom % 5) == 0);
    end
    for (int n = 0; n < 40; n++)
      step(1'b1, {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
           gen_line(1), 1'b0);
    step(1'b0, z, z, 1'b0);
    step(1'b0, z, z, 1'b0);
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule